// File: doc/BRIEF.md
# Peripheral Adapter Register Set

This block is a bus slave that sits between a microcomputer's system bus and the internal interface of one peripheral. The processor sees four logical registers: a receive data register, a transmit data register, a status register and a control register. The peripheral sees a one-byte receive strobe and a valid/ready transmit handshake. Status flags are kept in decoded form, one bit per condition, and are updated as bytes move in either direction.

The low byte of the bus address is the port byte. Its upper six bits carry a device number and its lower two bits pick a register. A strap input chooses how the adapter is selected. In isolated mode it answers only the dedicated I/O read and write strobes. In memory-mapped mode it answers only the memory read and write strobes, and only when the upper address byte equals a reserved page. A small bus-cycle state machine (`CYC_IDLE`, `CYC_READ`, `CYC_WRITE`) turns each strobe into exactly one register action, however long the strobe is held. Transitions: `CYC_IDLE` to `CYC_READ` on a selected read (read priority), `CYC_IDLE` to `CYC_WRITE` on a selected write, and `CYC_READ` or `CYC_WRITE` back to `CYC_IDLE` once the selected strobe is seen low.

Top module: `periph_adapter`

## Requirements
- R1: After reset, the status register reads 0x02 (transmit empty only). The control register reads 0x00. `bus_rd_oe`, `bus_rdata`, `irq` and `per_out_valid` are all 0.
- R2: A port byte selects the block only when bits 7:2 equal the device number (0x2A by default). Bits 1:0 pick the register: 00 = data (a read returns the receive byte, a write loads the transmit byte), 01 = status, 10 = control, 11 = reserved (reads 0x00, writes have no effect). An access with any other device number gets no response and changes no state.
- R3: With `mem_mapped` = 0, only `io_rd` and `io_wr` select the block, using `addr[7:0]`. Memory strobes have no effect.
- R4: With `mem_mapped` = 1, only `mem_rd` and `mem_wr` select the block, and only when `addr[15:8]` equals the page 0xF0. I/O strobes and other pages have no effect.
- R5: A selected read is captured at the first clock edge at which its strobe is sampled high. `bus_rd_oe` is 1 from that edge until the edge at which the strobe is sampled low. Outside that window `bus_rd_oe` is 0 and `bus_rdata` is 0x00.
- R6: When run is enabled, a `per_in_valid` cycle stores `per_in_data` and sets status bit 0 (receive full). A data-register read returns the stored byte and clears bit 0.
- R7: A data-register write while status bit 1 (transmit empty) is set stores the byte and clears bit 1. `per_out_valid` equals run AND NOT transmit-empty, with the byte on `per_out_data`. A `per_out_valid` AND `per_out_ready` cycle sets bit 1 again.
- R8: Status bit 2 (overrun) is set in two cases: a data write while transmit-empty is 0, or a receive while receive-full is 1. In both cases the new byte is dropped. Writing the control register with bit 2 set clears the overrun flag. Control bit 2 is a command and always reads back as 0.
- R9: Control bit 0 is run. While it is 0, `per_in_valid` is ignored and `per_out_valid` stays 0. The control register reads back bits 4:3 and 1:0 as written.
- R10: `irq` = control bit 1 (interrupt enable) AND ((control bit 3 AND receive full) OR (control bit 4 AND transmit empty)).
- R11: A strobe held for several cycles performs one action only: one write, or one read side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_mapped | input | 1 | Strap: 0 = isolated I/O, 1 = memory-mapped |
| addr | input | 16 | Bus address; bits 7:0 are the port byte |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data, 0 when not driving |
| bus_rd_oe | output | 1 | Read data drive enable for the bus pad |
| per_in_valid | input | 1 | Peripheral delivers a byte this cycle |
| per_in_data | input | 8 | Byte from the peripheral |
| per_out_valid | output | 1 | Transmit byte available to the peripheral |
| per_out_data | output | 8 | Transmit byte |
| per_out_ready | input | 1 | Peripheral accepts the transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
A read result appears one edge after its strobe is first sampled, and the drive enable drops one edge after the strobe is seen low. The bench therefore raises a strobe after a falling edge and samples the read data at the next falling edge. It confirms at the falling edge after release that the bus is no longer driven. Writes, peripheral strobes and handshakes take effect at the single edge inside their strobe. Their effect on the status flags, `per_out_valid` and `irq` is checked at the following falling edge, or through a status read issued afterwards. `irq` is combinational from registered state, so it is sampled at the falling edge right after the control write that changes it.

// File: rtl/periph_adapter_pkg.sv
package periph_adapter_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_state_t;

    // Register select codes in the low bits of the port byte
    localparam logic [1:0] RSEL_DATA = 2'b00;
    localparam logic [1:0] RSEL_STAT = 2'b01;
    localparam logic [1:0] RSEL_CTRL = 2'b10;

    // Status bit positions
    localparam int ST_IN_FULL   = 0;
    localparam int ST_OUT_EMPTY = 1;
    localparam int ST_OVERRUN   = 2;

    // Control bit positions
    localparam int CT_RUN     = 0;
    localparam int CT_IRQ_EN  = 1;
    localparam int CT_CLR_ERR = 2;
    localparam int CT_SRC_IN  = 3;
    localparam int CT_SRC_OUT = 4;

    typedef struct packed {
        logic src_out;
        logic src_in;
        logic irq_en;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/periph_adapter_decode.sv
module periph_adapter_decode #(
    parameter int          ADDR_W    = 16,
    parameter int          PORT_W    = 8,
    parameter int          DEV_W     = 6,
    parameter int unsigned DEV_ID    = 'h2A,
    parameter int unsigned MEM_PAGE  = 'hF0,
    localparam int         SEL_W     = PORT_W - DEV_W,
    localparam int         PAGE_W    = ADDR_W - PORT_W
) (
    input  logic              mem_mapped,
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              mem_rd,
    input  logic              mem_wr,
    output logic              rd_req,
    output logic              wr_req,
    output logic [SEL_W-1:0]  reg_sel
);

    logic dev_hit;
    logic page_hit;

    assign dev_hit = (addr[PORT_W-1:SEL_W] == DEV_W'(DEV_ID));
    assign reg_sel = addr[SEL_W-1:0];

    // The page compare exists only when the bus is wider than a port byte
    generate
        if (PAGE_W > 0) begin : g_page
            assign page_hit = (addr[ADDR_W-1:PORT_W] == PAGE_W'(MEM_PAGE));
        end else begin : g_nopage
            assign page_hit = 1'b1;
        end
    endgenerate

    always_comb begin
        if (mem_mapped) begin
            rd_req = dev_hit & page_hit & mem_rd;
            wr_req = dev_hit & page_hit & mem_wr;
        end else begin
            rd_req = dev_hit & io_rd;
            wr_req = dev_hit & io_wr;
        end
    end

endmodule

// File: rtl/periph_adapter_cycle.sv
module periph_adapter_cycle
    import periph_adapter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    output logic rd_fire,
    output logic wr_fire,
    output logic drive_en
);

    cyc_state_t state_q;
    cyc_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CYC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and one-shot action strobes
    always_comb begin
        state_d = state_q;
        rd_fire = 1'b0;
        wr_fire = 1'b0;
        unique case (state_q)
            CYC_IDLE: begin
                if (rd_req) begin
                    state_d = CYC_READ;
                    rd_fire = 1'b1;
                end else if (wr_req) begin
                    state_d = CYC_WRITE;
                    wr_fire = 1'b1;
                end
            end
            CYC_READ: begin
                if (!rd_req) begin
                    state_d = CYC_IDLE;
                end
            end
            CYC_WRITE: begin
                if (!wr_req) begin
                    state_d = CYC_IDLE;
                end
            end
            default: begin
                state_d = CYC_IDLE;
            end
        endcase
    end

    // Registered-state outputs
    always_comb begin
        drive_en = (state_q == CYC_READ);
    end

endmodule

// File: rtl/periph_adapter_regs.sv
module periph_adapter_regs
    import periph_adapter_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fire,
    input  logic              wr_fire,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              per_in_valid,
    input  logic [DATA_W-1:0] per_in_data,
    input  logic              per_out_ready,
    output logic              per_out_valid,
    output logic [DATA_W-1:0] per_out_data,
    output logic [DATA_W-1:0] rdata_q,
    output logic              irq,
    output logic              in_full,
    output logic              run,
    output logic              irq_en
);

    logic [DATA_W-1:0] in_data_q;
    logic [DATA_W-1:0] out_data_q;
    logic              in_full_q;
    logic              out_empty_q;
    logic              ovr_q;
    ctrl_t             ctrl_q;

    logic [DATA_W-1:0] status_vec;
    logic [DATA_W-1:0] ctrl_vec;
    logic              rx_evt;
    logic              tx_done;
    logic              data_wr;
    logic              data_rd;
    logic              ctrl_wr;
    logic              err_evt;

    // Decoded register actions
    assign data_wr = wr_fire & (reg_sel == SEL_W'(RSEL_DATA));
    assign data_rd = rd_fire & (reg_sel == SEL_W'(RSEL_DATA));
    assign ctrl_wr = wr_fire & (reg_sel == SEL_W'(RSEL_CTRL));

    // Peripheral-side events
    assign rx_evt  = per_in_valid & ctrl_q.run;
    assign tx_done = per_out_valid & per_out_ready;
    assign err_evt = (rx_evt & in_full_q) | (data_wr & ~out_empty_q);

    // Receive path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_full_q <= 1'b0;
            in_data_q <= '0;
        end else begin
            if (data_rd) begin
                in_full_q <= 1'b0;
            end
            if (rx_evt && !in_full_q) begin
                in_full_q <= 1'b1;
                in_data_q <= per_in_data;
            end
        end
    end

    // Transmit path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_empty_q <= 1'b1;
            out_data_q  <= '0;
        end else begin
            if (tx_done) begin
                out_empty_q <= 1'b1;
            end
            if (data_wr && out_empty_q) begin
                out_empty_q <= 1'b0;
                out_data_q  <= wdata;
            end
        end
    end

    // Overrun flag: a new error wins over a clear command in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else begin
            if (ctrl_wr && wdata[CT_CLR_ERR]) begin
                ovr_q <= 1'b0;
            end
            if (err_evt) begin
                ovr_q <= 1'b1;
            end
        end
    end

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.run     <= wdata[CT_RUN];
            ctrl_q.irq_en  <= wdata[CT_IRQ_EN];
            ctrl_q.src_in  <= wdata[CT_SRC_IN];
            ctrl_q.src_out <= wdata[CT_SRC_OUT];
        end
    end

    // Read-back images
    always_comb begin
        status_vec               = '0;
        status_vec[ST_IN_FULL]   = in_full_q;
        status_vec[ST_OUT_EMPTY] = out_empty_q;
        status_vec[ST_OVERRUN]   = ovr_q;
        ctrl_vec                 = '0;
        ctrl_vec[CT_RUN]         = ctrl_q.run;
        ctrl_vec[CT_IRQ_EN]      = ctrl_q.irq_en;
        ctrl_vec[CT_SRC_IN]      = ctrl_q.src_in;
        ctrl_vec[CT_SRC_OUT]     = ctrl_q.src_out;
    end

    // Read data captured once at the start of a read cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_fire) begin
            if (reg_sel == SEL_W'(RSEL_DATA)) begin
                rdata_q <= in_data_q;
            end else if (reg_sel == SEL_W'(RSEL_STAT)) begin
                rdata_q <= status_vec;
            end else if (reg_sel == SEL_W'(RSEL_CTRL)) begin
                rdata_q <= ctrl_vec;
            end else begin
                rdata_q <= '0;
            end
        end
    end

    assign per_out_valid = ctrl_q.run & ~out_empty_q;
    assign per_out_data  = out_data_q;
    assign irq           = ctrl_q.irq_en &
                           ((ctrl_q.src_in & in_full_q) | (ctrl_q.src_out & out_empty_q));
    assign in_full       = in_full_q;
    assign run           = ctrl_q.run;
    assign irq_en        = ctrl_q.irq_en;

endmodule

// File: rtl/periph_adapter.sv
module periph_adapter #(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          PORT_W   = 8,
    parameter int          DEV_W    = 6,
    parameter int unsigned DEV_ID   = 'h2A,
    parameter int unsigned MEM_PAGE = 'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_mapped,
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rd_oe,
    input  logic              per_in_valid,
    input  logic [DATA_W-1:0] per_in_data,
    output logic              per_out_valid,
    output logic [DATA_W-1:0] per_out_data,
    input  logic              per_out_ready,
    output logic              irq
);

    localparam int SEL_W = PORT_W - DEV_W;

    logic              rd_req;
    logic              wr_req;
    logic [SEL_W-1:0]  reg_sel;
    logic              rd_fire;
    logic              wr_fire;
    logic              drive_en;
    logic [DATA_W-1:0] rdata_q;
    logic              in_full;
    logic              run;
    logic              irq_en;

    periph_adapter_decode #(
        .ADDR_W   (ADDR_W),
        .PORT_W   (PORT_W),
        .DEV_W    (DEV_W),
        .DEV_ID   (DEV_ID),
        .MEM_PAGE (MEM_PAGE)
    ) u_decode (
        .mem_mapped (mem_mapped),
        .addr       (addr),
        .io_rd      (io_rd),
        .io_wr      (io_wr),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .rd_req     (rd_req),
        .wr_req     (wr_req),
        .reg_sel    (reg_sel)
    );

    periph_adapter_cycle u_cycle (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .rd_fire  (rd_fire),
        .wr_fire  (wr_fire),
        .drive_en (drive_en)
    );

    periph_adapter_regs #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_fire       (rd_fire),
        .wr_fire       (wr_fire),
        .reg_sel       (reg_sel),
        .wdata         (bus_wdata),
        .per_in_valid  (per_in_valid),
        .per_in_data   (per_in_data),
        .per_out_ready (per_out_ready),
        .per_out_valid (per_out_valid),
        .per_out_data  (per_out_data),
        .rdata_q       (rdata_q),
        .irq           (irq),
        .in_full       (in_full),
        .run           (run),
        .irq_en        (irq_en)
    );

    // Pad-side read path: zero whenever the bus is not being driven
    assign bus_rd_oe = drive_en;
    assign bus_rdata = drive_en ? rdata_q : '0;

endmodule

// File: rtl/periph_adapter_chk.sv
module periph_adapter_chk (
    input logic clk,
    input logic rst_n,
    input logic mem_mapped,
    input logic io_rd,
    input logic io_wr,
    input logic rd_req,
    input logic wr_req,
    input logic wr_fire,
    input logic drive_en,
    input logic per_in_valid,
    input logic in_full,
    input logic per_out_valid,
    input logic per_out_ready,
    input logic irq,
    input logic irq_en
);

    // R3: in isolated mode nothing is requested without an I/O strobe
    assert_iso_needs_io_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_mapped && !io_rd && !io_wr) |-> (!rd_req && !wr_req));

    // R5: the bus is driven only after a selected read was sampled
    assert_drive_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> $past(rd_req));

    // R6: receive-full rises only on a peripheral delivery
    assert_full_from_peripheral_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_full) |-> $past(per_in_valid));

    // R7: a completed handshake empties the transmit side
    assert_handshake_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (per_out_valid && per_out_ready) |=> !per_out_valid);

    // R10: no interrupt without the enable bit
    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);

    // R11: a write action never repeats on the next cycle
    assert_single_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !wr_fire);

endmodule

bind periph_adapter periph_adapter_chk i_periph_adapter_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_mapped    (mem_mapped),
    .io_rd         (io_rd),
    .io_wr         (io_wr),
    .rd_req        (rd_req),
    .wr_req        (wr_req),
    .wr_fire       (wr_fire),
    .drive_en      (drive_en),
    .per_in_valid  (per_in_valid),
    .in_full       (in_full),
    .per_out_valid (per_out_valid),
    .per_out_ready (per_out_ready),
    .irq           (irq),
    .irq_en        (irq_en)
);

// File: tb/test_periph_adapter.sv
module test_periph_adapter;

    localparam logic [5:0] DEV  = 6'h2A;
    localparam logic [7:0] PAGE = 8'hF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_mapped = 1'b0;
    logic [15:0] addr = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0, mem_rd = 1'b0, mem_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rd_oe;
    logic        per_in_valid = 1'b0;
    logic [7:0]  per_in_data = '0;
    logic        per_out_valid;
    logic [7:0]  per_out_data;
    logic        per_out_ready = 1'b0;
    logic        irq;

    int vectors = 0;
    int miscompares = 0;

    // Bench-side model of the register state, built from the requirements
    bit       m_in_full, m_out_empty, m_ovr;
    bit [7:0] m_in_data, m_out_data;
    bit [4:0] m_ctrl;

    periph_adapter #(.DEV_ID('h2A), .MEM_PAGE('hF0)) i_periph_adapter (
        .clk(clk), .rst_n(rst_n), .mem_mapped(mem_mapped), .addr(addr),
        .io_rd(io_rd), .io_wr(io_wr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rd_oe(bus_rd_oe),
        .per_in_valid(per_in_valid), .per_in_data(per_in_data),
        .per_out_valid(per_out_valid), .per_out_data(per_out_data),
        .per_out_ready(per_out_ready), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    function automatic bit selected(input logic [15:0] a, input bit use_mem);
        if (a[7:2] != DEV) return 1'b0;
        if (mem_mapped) return use_mem && (a[15:8] == PAGE);
        return !use_mem;
    endfunction

    function automatic bit [7:0] model_read(input logic [1:0] s);
        bit [7:0] r;
        case (s)
            2'b00: begin r = m_in_data; m_in_full = 1'b0; end
            2'b01: r = {5'b0, m_ovr, m_out_empty, m_in_full};
            2'b10: r = {3'b0, m_ctrl};
            default: r = 8'h00;
        endcase
        return r;
    endfunction

    function automatic void model_write(input logic [1:0] s, input bit [7:0] v);
        if (s == 2'b00) begin
            if (m_out_empty) begin m_out_empty = 1'b0; m_out_data = v; end
            else m_ovr = 1'b1;
        end else if (s == 2'b10) begin
            if (v[2]) m_ovr = 1'b0;
            m_ctrl = v[4:0] & 5'b11011;
        end
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; io_rd = 0; io_wr = 0; mem_rd = 0; mem_wr = 0;
        per_in_valid = 0; per_out_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_in_full = 0; m_out_empty = 1; m_ovr = 0;
        m_in_data = 0; m_out_data = 0; m_ctrl = 0;
        @(negedge clk);
    endtask

    // Read cycle with check against the model
    task automatic rd_chk(input logic [15:0] a, input bit use_mem, input string tag);
        bit sel;
        bit [7:0] exp;
        sel = selected(a, use_mem);
        @(negedge clk);
        addr = a;
        if (use_mem) mem_rd = 1'b1; else io_rd = 1'b1;
        @(negedge clk);
        if (sel) begin
            exp = model_read(a[1:0]);
            chk(bus_rd_oe == 1'b1, {tag, " oe"}, bus_rd_oe, 1);
            chk(bus_rdata == exp, {tag, " data"}, bus_rdata, exp);
        end else begin
            chk(bus_rd_oe == 1'b0 && bus_rdata == 8'h00, {tag, " no response"},
                {bus_rd_oe, bus_rdata}, 0);
        end
        io_rd = 1'b0; mem_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_do(input logic [15:0] a, input bit use_mem, input bit [7:0] v);
        bit sel;
        sel = selected(a, use_mem);
        @(negedge clk);
        addr = a; bus_wdata = v;
        if (use_mem) mem_wr = 1'b1; else io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; mem_wr = 1'b0;
        if (sel) model_write(a[1:0], v);
        @(negedge clk);
    endtask

    task automatic push(input bit [7:0] v);
        @(negedge clk);
        per_in_valid = 1'b1; per_in_data = v;
        @(negedge clk);
        per_in_valid = 1'b0;
        if (m_ctrl[0]) begin
            if (m_in_full) m_ovr = 1'b1;
            else begin m_in_full = 1'b1; m_in_data = v; end
        end
    endtask

    task automatic take();
        @(negedge clk);
        per_out_ready = 1'b1;
        @(negedge clk);
        per_out_ready = 1'b0;
        if (m_ctrl[0] && !m_out_empty) m_out_empty = 1'b1;
    endtask

    task automatic chk_out(input string tag);
        chk(per_out_valid == (m_ctrl[0] & ~m_out_empty), {tag, " per_out_valid"},
            per_out_valid, m_ctrl[0] & ~m_out_empty);
        if (per_out_valid)
            chk(per_out_data == m_out_data, {tag, " per_out_data"}, per_out_data, m_out_data);
    endtask

    function automatic logic [15:0] dev_addr(input logic [7:0] page, input logic [1:0] s);
        return {page, DEV, s};
    endfunction

    initial begin
        do_reset();

        // R1: reset state
        chk(bus_rd_oe == 0 && bus_rdata == 0, "R1 bus idle", {bus_rd_oe, bus_rdata}, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        chk(per_out_valid == 0, "R1 per_out_valid", per_out_valid, 0);
        rd_chk(dev_addr(8'h00, 2'b01), 0, "R1 status");
        rd_chk(dev_addr(8'h00, 2'b10), 0, "R1 control");

        wr_do(dev_addr(8'h00, 2'b10), 0, 8'h01);

        // R5: drive window timing
        @(negedge clk);
        addr = dev_addr(8'h00, 2'b01); io_rd = 1'b1;
        #1 chk(bus_rd_oe == 0, "R5 oe before first edge", bus_rd_oe, 0);
        @(negedge clk);
        chk(bus_rd_oe == 1, "R5 oe after first edge", bus_rd_oe, 1);
        @(negedge clk);
        chk(bus_rd_oe == 1, "R5 oe while strobe held", bus_rd_oe, 1);
        io_rd = 1'b0;
        @(negedge clk);
        chk(bus_rd_oe == 0 && bus_rdata == 0, "R5 released", {bus_rd_oe, bus_rdata}, 0);

        // R6: delivery then sweep of every port byte in isolated mode (R2, R3)
        push(8'h5A);
        rd_chk(dev_addr(8'h00, 2'b01), 0, "R6 status full");
        for (int p = 0; p < 256; p++) rd_chk({8'h00, 8'(p)}, 0, "R2 R3 io read sweep");
        rd_chk(dev_addr(8'h00, 2'b00), 0, "R6 data after clear");

        // R3: memory strobes ignored in isolated mode
        for (int s = 0; s < 4; s++) rd_chk(dev_addr(PAGE, 2'(s)), 1, "R3 mem read ignored");
        wr_do(dev_addr(PAGE, 2'b00), 1, 8'hC3);
        rd_chk(dev_addr(8'h00, 2'b01), 0, "R3 mem write ignored");

        // R2: writes to every other port byte change nothing
        for (int p = 0; p < 256; p++)
            if (p[7:2] != DEV || p[1:0] == 2'b11) wr_do({8'h00, 8'(p)}, 0, 8'hFF);
        rd_chk(dev_addr(8'h00, 2'b10), 0, "R2 control untouched");
        rd_chk(dev_addr(8'h00, 2'b01), 0, "R2 status untouched");
        rd_chk(dev_addr(8'h00, 2'b11), 0, "R2 reserved reads zero");
        chk_out("R2");

        // R7 / R8: transmit path and transmit overrun
        wr_do(dev_addr(8'h00, 2'b00), 0, 8'h3C);
        chk_out("R7 loaded");
        wr_do(dev_addr(8'h00, 2'b00), 0, 8'h99);
        chk_out("R8 dropped write");
        rd_chk(dev_addr(8'h00, 2'b01), 0, "R8 status overrun");
        take();
        chk_out("R7 accepted");
        rd_chk(dev_addr(8'h00, 2'b01), 0, "R7 status empty");
        wr_do(dev_addr(8'h00, 2'b10), 0, 8'h05);
        rd_chk(dev_addr(8'h00, 2'b01), 0, "R8 cleared");
        rd_chk(dev_addr(8'h00, 2'b10), 0, "R8 clear bit reads zero");

        // R8: receive overrun
        push(8'h21);
        push(8'h22);
        rd_chk(dev_addr(8'h00, 2'b01), 0, "R8 rx overrun status");
        rd_chk(dev_addr(8'h00, 2'b00), 0, "R8 first byte kept");
        wr_do(dev_addr(8'h00, 2'b10), 0, 8'h05);

        // R9: run cleared blocks peripheral side
        wr_do(dev_addr(8'h00, 2'b10), 0, 8'h00);
        push(8'h77);
        rd_chk(dev_addr(8'h00, 2'b01), 0, "R9 push ignored");
        wr_do(dev_addr(8'h00, 2'b00), 0, 8'h11);
        chk_out("R9 valid held low");
        take();
        rd_chk(dev_addr(8'h00, 2'b01), 0, "R9 take ignored");
        wr_do(dev_addr(8'h00, 2'b10), 0, 8'h01);
        chk_out("R9 valid after run");
        take();
        chk_out("R9 drained");

        // R11: long write strobe gives one write
        @(negedge clk);
        addr = dev_addr(8'h00, 2'b00); bus_wdata = 8'h42; io_wr = 1'b1;
        repeat (3) @(negedge clk);
        io_wr = 1'b0;
        model_write(2'b00, 8'h42);
        @(negedge clk);
        rd_chk(dev_addr(8'h00, 2'b01), 0, "R11 single write");
        chk_out("R11 out byte");
        take();

        // R11: long read strobe clears receive-full only once
        push(8'h99);
        @(negedge clk);
        addr = dev_addr(8'h00, 2'b00); io_rd = 1'b1;
        @(negedge clk);
        chk(bus_rdata == 8'h99, "R11 long read data", bus_rdata, 8'h99);
        void'(model_read(2'b00));
        per_in_valid = 1'b1; per_in_data = 8'h66;
        @(negedge clk);
        per_in_valid = 1'b0; m_in_full = 1'b1; m_in_data = 8'h66;
        @(negedge clk);
        io_rd = 1'b0;
        @(negedge clk);
        rd_chk(dev_addr(8'h00, 2'b01), 0, "R11 single read clear");
        rd_chk(dev_addr(8'h00, 2'b00), 0, "R11 new byte");

        // R4: memory-mapped mode
        @(negedge clk);
        mem_mapped = 1'b1;
        push(8'hA5);
        for (int g = 0; g < 4; g++) begin
            logic [7:0] pg;
            pg = (g == 0) ? PAGE : (g == 1) ? 8'hF1 : (g == 2) ? 8'h70 : 8'h00;
            for (int p = 0; p < 256; p++) rd_chk({pg, 8'(p)}, 1, "R4 mem read sweep");
        end
        push(8'h5B);
        for (int s = 0; s < 4; s++) rd_chk(dev_addr(PAGE, 2'(s)), 0, "R4 io read ignored");
        wr_do(dev_addr(PAGE, 2'b10), 0, 8'h1B);
        wr_do(dev_addr(8'hF1, 2'b10), 1, 8'h1B);
        rd_chk(dev_addr(PAGE, 2'b10), 1, "R4 stray writes ignored");
        wr_do(dev_addr(PAGE, 2'b10), 1, 8'h0B);
        rd_chk(dev_addr(PAGE, 2'b10), 1, "R4 mem write accepted");
        rd_chk(dev_addr(PAGE, 2'b00), 1, "R4 data read");
        @(negedge clk);
        mem_mapped = 1'b0;

        // R10: interrupt over all control values and flag combinations
        for (int combo = 0; combo < 4; combo++) begin
            do_reset();
            wr_do(dev_addr(8'h00, 2'b10), 0, 8'h01);
            if (combo[0]) push(8'h10);
            if (combo[1]) wr_do(dev_addr(8'h00, 2'b00), 0, 8'h20);
            for (int c = 0; c < 32; c++) begin
                bit e;
                wr_do(dev_addr(8'h00, 2'b10), 0, 8'(c));
                e = m_ctrl[1] & ((m_ctrl[3] & m_in_full) | (m_ctrl[4] & m_out_empty));
                chk(irq == e, "R10 irq", irq, e);
                rd_chk(dev_addr(8'h00, 2'b10), 0, "R9 R10 control readback");
            end
            rd_chk(dev_addr(8'h00, 2'b01), 0, "R10 flags kept");
        end

        summary();
    end

endmodule